// File: doc/BRIEF.md
# Host Configuration Register Interface

This block sits between a byte-wide host processor port and the configuration core of a programmable device. The host selects one of four registers with a two-bit address. It streams configuration bytes into the device through a data register and writes a 16-bit readback address into two byte registers. It reads configuration bytes back through the same data register. A read-only status register tells it when to move the next byte, whether user logic is raising an interrupt, whether the bitstream was rejected and with what cause, and the present level of two device pins.

On the core side, a one-cycle `cfg_space` pulse means the core can take another configuration byte. Each accepted host byte is forwarded as a one-cycle `cfg_valid` pulse. In readback mode a one-cycle `rb_avail` pulse loads `rb_byte` into the data register. The core reports bitstream errors as a nonzero code. The `reprogram` input wipes that code. Each status bit has its own clear rule. When a set event and a clear event reach the same bit in one cycle, the set event wins.

Top module: `cfg_host_regs`

## Requirements
- R1: After reset, `cfg_valid` is 0, `h_rdata` is 0 and `rb_addr` is 0. The status register (address 0) reads bit 7 = live `done_level`, bit 6 = live `init_level`, bits 5 and 0 = 0, bits [4:3] = error code, bit 2 = interrupt-pending and bit 1 = data-ready. Error code, interrupt-pending and data-ready are all 0 after reset.
- R2: A read strobe `h_rd` with address A puts register A on `h_rdata` at the next clock edge. `h_rdata` holds that value until the next read strobe. Address map: 0 = status, 1 = data, 2 = readback address low byte, 3 = readback address high byte.
- R3: Data-ready is set by `cfg_space` when `rb_mode` = 0 and by `rb_avail` when `rb_mode` = 1. Any host read or write of address 1 clears it. A set event in the same cycle as a clear wins.
- R4: A host write to address 1 with `rb_mode` = 0 and data-ready = 1 produces, one cycle later, `cfg_valid` = 1 for exactly one cycle with `cfg_byte` equal to the written byte.
- R5: A host write to address 1 is ignored when data-ready is 0 or `rb_mode` is 1: no `cfg_valid` pulse, and the data register keeps its earlier value.
- R6: When `rb_mode` = 1, an `rb_avail` pulse loads `rb_byte` into the data register, and a host read of address 1 returns it. When `rb_mode` = 0, address 1 reads back the last accepted configuration byte.
- R7: Interrupt-pending is set in every cycle in which `usr_irq` is 1. A status read clears it, unless `usr_irq` is 1 in that cycle. A status read returns the value held before the clear.
- R8: A nonzero `err_code` (01 = ID error, 10 = checksum error, 11 = stop-bit or alignment error) loads status bits [4:3], with bit 3 as the LSB. Status reads never clear it. Only `reprogram` = 1 clears it to 00, and a nonzero code in the same cycle wins over `reprogram`.
- R9: A write to address 2 sets `rb_addr[7:0]` and a write to address 3 sets `rb_addr[15:8]`. Both registers read back through addresses 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_addr | input | 2 | Host register select |
| h_rd | input | 1 | Host read strobe, one cycle |
| h_wr | input | 1 | Host write strobe, one cycle |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Registered host read byte |
| rb_mode | input | 1 | 0 = configuration mode, 1 = readback mode |
| cfg_space | input | 1 | Core can accept another configuration byte (pulse) |
| cfg_valid | output | 1 | Configuration byte forwarded to core (pulse) |
| cfg_byte | output | 8 | Forwarded configuration byte |
| rb_avail | input | 1 | Readback byte present on `rb_byte` (pulse) |
| rb_byte | input | 8 | Readback byte from core |
| rb_addr | output | 16 | Readback address |
| err_code | input | 2 | Bitstream error report, nonzero = error |
| reprogram | input | 1 | Program request, clears the error code |
| usr_irq | input | 1 | Interrupt request from user logic |
| init_level | input | 1 | Init pin level, mirrored in status |
| done_level | input | 1 | Done pin level, mirrored in status |

## Verification
The bench builds the block with the default byte width of 8. This makes the data path exactly one byte wide and the readback address 16 bits, so every configuration byte value and every readback byte value can be pushed through the data register in a full sweep. The same width lets all four error codes, both pin levels and 256 address pairs be covered. Each set-versus-clear collision is driven in a single cycle to show that the set event wins.

// File: rtl/cfg_host_regs.sv
`timescale 1ns/1ps
module cfg_host_regs #(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            h_addr,
  input  logic                  h_rd,
  input  logic                  h_wr,
  input  logic [DATA_W-1:0]     h_wdata,
  output logic [DATA_W-1:0]     h_rdata,
  input  logic                  rb_mode,
  input  logic                  cfg_space,
  output logic                  cfg_valid,
  output logic [DATA_W-1:0]     cfg_byte,
  input  logic                  rb_avail,
  input  logic [DATA_W-1:0]     rb_byte,
  output logic [2*DATA_W-1:0]   rb_addr,
  input  logic [1:0]            err_code,
  input  logic                  reprogram,
  input  logic                  usr_irq,
  input  logic                  init_level,
  input  logic                  done_level
);

  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_RBLO = 2'd2;
  localparam logic [1:0] A_RBHI = 2'd3;

  logic              rdy_q, irq_q;
  logic [1:0]        err_q;
  logic [DATA_W-1:0] data_q, rb_lo_q, rb_hi_q;
  logic [7:0]        status;

  wire data_acc = (h_rd | h_wr) & (h_addr == A_DATA);
  wire rdy_set  = rb_mode ? rb_avail : cfg_space;
  wire fwd      = h_wr & (h_addr == A_DATA) & ~rb_mode & rdy_q;
  wire stat_rd  = h_rd & (h_addr == A_STAT);

  assign status   = {done_level, init_level, 1'b0, err_q, irq_q, rdy_q, 1'b0};
  assign cfg_byte = data_q;
  assign rb_addr  = {rb_hi_q, rb_lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      irq_q <= 1'b0;
      err_q <= 2'b00;
    end else begin
      if (rdy_set)       rdy_q <= 1'b1;
      else if (data_acc) rdy_q <= 1'b0;
      if (usr_irq)       irq_q <= 1'b1;
      else if (stat_rd)  irq_q <= 1'b0;
      if (err_code != 2'b00) err_q <= err_code;
      else if (reprogram)    err_q <= 2'b00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q    <= '0;
      cfg_valid <= 1'b0;
      rb_lo_q   <= '0;
      rb_hi_q   <= '0;
    end else begin
      cfg_valid <= fwd;
      if (rb_mode && rb_avail) data_q <= rb_byte;
      else if (fwd)            data_q <= h_wdata;
      if (h_wr && h_addr == A_RBLO) rb_lo_q <= h_wdata;
      if (h_wr && h_addr == A_RBHI) rb_hi_q <= h_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) h_rdata <= '0;
    else if (h_rd) begin
      case (h_addr)
        A_STAT:  h_rdata <= DATA_W'(status);
        A_DATA:  h_rdata <= data_q;
        A_RBLO:  h_rdata <= rb_lo_q;
        default: h_rdata <= rb_hi_q;
      endcase
    end
  end

  p_rdy_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_set |=> rdy_q);
  p_rdy_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !rdy_set) |=> !rdy_q);
  p_fwd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == A_DATA && !rb_mode && rdy_q) |=> (cfg_valid && cfg_byte == $past(h_wdata)));
  p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == A_DATA && (!rdy_q || rb_mode)) |=> !cfg_valid);
  p_irq_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    usr_irq |=> irq_q);
  p_irq_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !usr_irq) |=> !irq_q);
  p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code == 2'b00 && !reprogram) |=> $stable(err_q));
  p_err_wipe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code == 2'b00 && reprogram) |=> err_q == 2'b00);
  p_addr_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == A_RBLO) |=> rb_addr[DATA_W-1:0] == $past(h_wdata));

endmodule

// File: tb/tb_cfg_host_regs.sv
`timescale 1ns/1ps
module tb_cfg_host_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] h_addr = '0;
  logic h_rd = 0, h_wr = 0;
  logic [7:0] h_wdata = '0, h_rdata;
  logic rb_mode = 0, cfg_space = 0, cfg_valid, rb_avail = 0;
  logic [7:0] cfg_byte, rb_byte = '0;
  logic [15:0] rb_addr;
  logic [1:0] err_code = '0;
  logic reprogram = 0, usr_irq = 0, init_level = 1, done_level = 0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  cfg_host_regs dut (.clk, .rst_n, .h_addr, .h_rd, .h_wr, .h_wdata, .h_rdata,
    .rb_mode, .cfg_space, .cfg_valid, .cfg_byte, .rb_avail, .rb_byte, .rb_addr,
    .err_code, .reprogram, .usr_irq, .init_level, .done_level);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stat(input bit dn, input bit in, input logic [1:0] e,
                                      input bit irq, input bit rdy);
    return 8'(dn) * 128 + 8'(in) * 64 + 8'(e) * 8 + 8'(irq) * 4 + 8'(rdy) * 2;
  endfunction

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    h_rd = 1; h_addr = a; @(negedge clk); h_rd = 0; v = h_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, output bit cv, output logic [7:0] cb);
    h_wr = 1; h_addr = a; h_wdata = d; @(negedge clk); h_wr = 0; cv = cfg_valid; cb = cfg_byte;
  endtask

  task automatic pulse_space(); cfg_space = 1; @(negedge clk); cfg_space = 0; endtask
  task automatic idle(); @(negedge clk); endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v, cb, last;
    bit cv;
    repeat (3) @(negedge clk);
    check(cfg_valid == 0 && h_rdata == 0 && rb_addr == 0, "R1 reset outputs",
          {cfg_valid, h_rdata, rb_addr}, 0);
    rst_n = 1; idle();
    rd(2'd0, v); check(v == stat(0,1,0,0,0), "R1 status reset", v, stat(0,1,0,0,0));
    init_level = 0; done_level = 1;
    rd(2'd0, v); check(v == stat(1,0,0,0,0), "R1 live pins", v, stat(1,0,0,0,0));
    init_level = 1; done_level = 1;
    rd(2'd0, v); check(v == stat(1,1,0,0,0), "R1 live pins both", v, stat(1,1,0,0,0));
    idle(); idle();
    check(h_rdata == stat(1,1,0,0,0), "R2 read data holds", h_rdata, stat(1,1,0,0,0));
    init_level = 0; done_level = 0;

    wr(2'd1, 8'h5A, cv, cb);
    check(!cv, "R5 write with data-ready low", cv, 0);
    rd(2'd1, v); check(v == 8'h00, "R5 data register unchanged", v, 0);

    for (int b = 0; b < 256; b++) begin
      pulse_space();
      rd(2'd0, v); check(v == stat(0,0,0,0,1), "R3 ready set in config mode", v, stat(0,0,0,0,1));
      wr(2'd1, 8'(b), cv, cb);
      check(cv && cb == 8'(b), "R4 byte forwarded", {cv, cb}, {1'b1, 8'(b)});
      idle();
      check(!cfg_valid, "R4 single-cycle pulse", cfg_valid, 0);
      rd(2'd0, v); check(v == stat(0,0,0,0,0), "R3 write clears ready", v, 0);
      wr(2'd1, ~8'(b), cv, cb);
      check(!cv, "R5 second write dropped", cv, 0);
      rd(2'd1, v); check(v == 8'(b), "R6 config byte reads back", v, 8'(b));
    end

    pulse_space();
    rd(2'd1, v);
    rd(2'd0, v); check(v == stat(0,0,0,0,0), "R3 data read clears ready", v, 0);

    pulse_space();
    cfg_space = 1; h_wr = 1; h_addr = 2'd1; h_wdata = 8'h3C; @(negedge clk);
    cfg_space = 0; h_wr = 0;
    check(cfg_valid && cfg_byte == 8'h3C, "R4 forward during collision", cfg_byte, 8'h3C);
    rd(2'd0, v); check(v == stat(0,0,0,0,1), "R3 set wins over clear", v, stat(0,0,0,0,1));
    rd(2'd1, v);

    rb_mode = 1;
    for (int b = 0; b < 256; b++) begin
      rb_byte = 8'(b) ^ 8'hA5; rb_avail = 1; @(negedge clk); rb_avail = 0; rb_byte = 0;
      rd(2'd0, v); check(v == stat(0,0,0,0,1), "R3 ready set in readback", v, stat(0,0,0,0,1));
      wr(2'd1, 8'h11, cv, cb);
      check(!cv, "R5 write in readback mode dropped", cv, 0);
      rd(2'd0, v); check(v == stat(0,0,0,0,0), "R3 readback write clears ready", v, 0);
      rd(2'd1, v); check(v == (8'(b) ^ 8'hA5), "R6 readback byte", v, 8'(b) ^ 8'hA5);
    end
    cfg_space = 1; @(negedge clk); cfg_space = 0;
    rd(2'd0, v); check(v == stat(0,0,0,0,0), "R3 space ignored in readback", v, 0);
    rb_mode = 0;

    usr_irq = 1; idle(); usr_irq = 0;
    rd(2'd0, v); check(v == stat(0,0,0,1,0), "R7 pending set", v, stat(0,0,0,1,0));
    rd(2'd0, v); check(v == stat(0,0,0,0,0), "R7 status read clears", v, 0);
    usr_irq = 1; idle();
    rd(2'd0, v); rd(2'd0, v);
    check(v == stat(0,0,0,1,0), "R7 held request wins", v, stat(0,0,0,1,0));
    usr_irq = 0;
    rd(2'd0, v); rd(2'd0, v); check(v == stat(0,0,0,0,0), "R7 cleared after release", v, 0);

    for (int c = 1; c < 4; c++) begin
      err_code = 2'(c); idle(); err_code = 0;
      rd(2'd0, v); check(v == stat(0,0,2'(c),0,0), "R8 error code", v, stat(0,0,2'(c),0,0));
      rd(2'd0, v); check(v == stat(0,0,2'(c),0,0), "R8 read keeps code", v, stat(0,0,2'(c),0,0));
      reprogram = 1; idle(); reprogram = 0;
      rd(2'd0, v); check(v == stat(0,0,0,0,0), "R8 reprogram clears", v, 0);
    end
    err_code = 2'd2; reprogram = 1; idle(); err_code = 0; reprogram = 0;
    rd(2'd0, v); check(v == stat(0,0,2'd2,0,0), "R8 load wins over reprogram", v, stat(0,0,2'd2,0,0));
    reprogram = 1; idle(); reprogram = 0;

    for (int i = 0; i < 256; i++) begin
      wr(2'd2, 8'(i), cv, cb);
      wr(2'd3, 8'(255 - i), cv, cb);
      check(rb_addr == {8'(255 - i), 8'(i)}, "R9 readback address", rb_addr, {8'(255 - i), 8'(i)});
      rd(2'd2, v); check(v == 8'(i), "R9 low byte reads back", v, 8'(i));
      rd(2'd3, last); check(last == 8'(255 - i), "R9 high byte reads back", last, 8'(255 - i));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule